// File: doc/BRIEF.md
# Timer Event Status Register

This block keeps the sticky event flags of a general-purpose timer that has one counter, two compare registers and two capture inputs. Single-cycle event pulses for counter overflow, compare 0 match, compare 1 match, capture 0 and capture 1 each set their own status flag. The flags stay set until software clears them through a 32-bit register port with write-one-to-clear behaviour. Within the timer's register block the register sits at byte offset 0x58. Address decoding happens outside this block, so `wrEn` arrives already qualified for this register.

An interrupt request is formed from the flags and a separate 5-bit enable mask. Masking an event only stops its interrupt. The flag is still set.

The two compare flags have one extra rule. Suppose the timer is stopped and a compare value equals the counter. Then the compare flag cannot be cleared until the counter or that same compare register has been written since the flag was last set. The block watches the counter value, both compare values, the running flag and the write strobes of those registers so that it can decide this lock.

Top module: `tmr_evt_status`

## Requirements
- R1: Status bit positions are: bit 0 overflow, bit 1 compare 0, bit 2 compare 1, bit 3 capture 0, bit 4 capture 1 (matching `eventPulse` bit positions). Read bits 31:5 are always zero, and writes to them are ignored.
- R2: After reset every status bit reads 0 and `irqOut` is 0.
- R3: A pulse on `eventPulse[i]` makes status bit i read 1 from the next cycle on. This holds whatever the value of `intEn`.
- R4: A write with `wrData[i]`=1 clears set status bit i in the next cycle, and the interrupt that bit drove drops with it (lock case excepted, see R8).
- R5: A write with `wrData[i]`=0 leaves bit i unchanged. A write of 1 to a bit that is already 0 leaves it 0.
- R6: If an event and a write-1 clear of the same bit fall in the same cycle, the bit ends up 1.
- R7: `irqOut` equals the OR over i of status bit i AND `intEn[i]`, without added delay.
- R8: Status bit 1+k (compare k) refuses a write-1 clear when all three of these hold in the write cycle: `timerRun`=0, compare k value equals `cntVal`, and no counter or compare k write strobe has been seen since the flag was last set by an event. A new compare k event re-arms the lock.
- R9: After a `cntWrStb`, or a write strobe of compare k, a later write-1 clears compare bit k even if the values still match. A write strobe of the other compare register does not unlock it.
- R10: While `timerRun`=1 the compare flags clear normally on write-1, even when the values match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventPulse | input | 5 | Event pulses, bit map as in R1 |
| intEn | input | 5 | Interrupt enable per status bit |
| timerRun | input | 1 | 1 while the counter is running |
| cntVal | input | CNT_W | Current counter value |
| cmp0Val | input | CNT_W | Compare register 0 value |
| cmp1Val | input | CNT_W | Compare register 1 value |
| cntWrStb | input | 1 | Counter register written this cycle |
| cmp0WrStb | input | 1 | Compare 0 register written this cycle |
| cmp1WrStb | input | 1 | Compare 1 register written this cycle |
| wrEn | input | 1 | Write to this status register |
| wrData | input | 32 | Write data, 1 clears the bit |
| rdData | output | 32 | Current status, bits 31:5 zero |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that the counter and compare value inputs only change in a cycle that also carries the matching write strobe, or while the timer runs. Otherwise the lock checks could see a value change that the block was never told about. They also assume a synchronous reset that is low at time zero. The stimulus moves `cntVal`, `cmp0Val` and `cmp1Val` only together with their strobes, or while `timerRun` is high. It changes inputs only on the falling clock edge, so every event, write and strobe is seen for exactly one rising edge.

// File: rtl/tesr_pkg.sv
package tesr_pkg;
  localparam int NUM_EVT  = 5;
  localparam int NUM_CMP  = 2;
  localparam int BUS_W    = 32;
  localparam int IDX_OVF  = 0;
  localparam int IDX_CMP0 = 1;
  localparam int IDX_CAP0 = IDX_CMP0 + NUM_CMP;

  typedef struct packed {
    logic [NUM_EVT-1:0] setBits;
    logic [NUM_EVT-1:0] clrBits;
    logic [NUM_CMP-1:0] chgSet;
    logic [NUM_CMP-1:0] chgClr;
  } statStrb_t;
endpackage

// File: rtl/tesr_ctrl.sv
module tesr_ctrl
  import tesr_pkg::*;
(
  input  logic [NUM_EVT-1:0] eventPulse,
  input  logic               wrEn,
  input  logic [NUM_EVT-1:0] wrLow,
  input  logic               timerRun,
  input  logic               cntWrStb,
  input  logic [NUM_CMP-1:0] cmpWrStb,
  input  logic [NUM_CMP-1:0] cmpMatch,
  input  logic [NUM_CMP-1:0] chgSeen,
  output statStrb_t          strb
);
  logic [NUM_EVT-1:0] clrReq;
  logic [NUM_CMP-1:0] lockCmp;

  // plain bits: clear on write-one
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_req
    if (i >= IDX_CMP0 && i < IDX_CAP0) begin : g_cmpbit
      // compare bits obey the stopped-match lock
      assign lockCmp[i-IDX_CMP0] = !timerRun && cmpMatch[i-IDX_CMP0]
                                   && !chgSeen[i-IDX_CMP0];
      assign clrReq[i] = wrEn && wrLow[i] && !lockCmp[i-IDX_CMP0];
    end else begin : g_plain
      assign clrReq[i] = wrEn && wrLow[i];
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_chg
    assign strb.chgClr[k] = eventPulse[IDX_CMP0+k];
    assign strb.chgSet[k] = cntWrStb || cmpWrStb[k];
  end

  // an event in the same cycle as its clear wins
  assign strb.setBits = eventPulse;
  assign strb.clrBits = clrReq & ~eventPulse;
endmodule

// File: rtl/tesr_dp.sv
module tesr_dp
  import tesr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  statStrb_t          strb,
  input  logic [NUM_EVT-1:0] intEn,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [CNT_W-1:0]   cmpVal [NUM_CMP],
  output logic [NUM_CMP-1:0] cmpMatch,
  output logic [NUM_CMP-1:0] chgSeen,
  output logic [BUS_W-1:0]   rdData,
  output logic               irqOut
);
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_CMP-1:0] chgSeenQ;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign cmpMatch[k] = (cmpVal[k] == cntVal);

    always_ff @(posedge clk) begin
      if (!rstN)                chgSeenQ[k] <= 1'b0;
      else if (strb.chgClr[k])  chgSeenQ[k] <= 1'b0;
      else if (strb.chgSet[k])  chgSeenQ[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~strb.clrBits) | strb.setBits;
  end

  assign chgSeen = chgSeenQ;
  assign rdData  = {{(BUS_W-NUM_EVT){1'b0}}, statusQ};
  assign irqOut  = |(statusQ & intEn);
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tesr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] eventPulse,
  input  logic [NUM_EVT-1:0] intEn,
  input  logic               timerRun,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [CNT_W-1:0]   cmp0Val,
  input  logic [CNT_W-1:0]   cmp1Val,
  input  logic               cntWrStb,
  input  logic               cmp0WrStb,
  input  logic               cmp1WrStb,
  input  logic               wrEn,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   rdData,
  output logic               irqOut
);
  statStrb_t          strb;
  logic [NUM_CMP-1:0] cmpMatch;
  logic [NUM_CMP-1:0] chgSeen;
  logic [CNT_W-1:0]   cmpVal [NUM_CMP];
  logic               unusedRsvd;

  assign cmpVal[0]  = cmp0Val;
  assign cmpVal[1]  = cmp1Val;
  assign unusedRsvd = ^wrData[BUS_W-1:NUM_EVT];

  tesr_ctrl u_ctrl (
    .eventPulse (eventPulse),
    .wrEn       (wrEn),
    .wrLow      (wrData[NUM_EVT-1:0]),
    .timerRun   (timerRun),
    .cntWrStb   (cntWrStb),
    .cmpWrStb   ({cmp1WrStb, cmp0WrStb}),
    .cmpMatch   (cmpMatch),
    .chgSeen    (chgSeen),
    .strb       (strb)
  );

  tesr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .intEn    (intEn),
    .cntVal   (cntVal),
    .cmpVal   (cmpVal),
    .cmpMatch (cmpMatch),
    .chgSeen  (chgSeen),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/tesr_chk.sv
module tesr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [4:0]       eventPulse,
  input logic [4:0]       intEn,
  input logic             timerRun,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] cmp0Val,
  input logic [CNT_W-1:0] cmp1Val,
  input logic             wrEn,
  input logic [4:0]       wrLow,
  input logic [1:0]       chgSeen,
  input logic [31:0]      rdData,
  input logic             irqOut
);
  logic [4:0] wrMask;
  assign wrMask = wrEn ? wrLow : 5'b0;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:5] == 27'b0);

  // R3
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventPulse != 5'b0) |=> ((rdData[4:0] & $past(eventPulse)) == $past(eventPulse)));

  // R4
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrLow[0] && !eventPulse[0]) |=> !rdData[0]);

  // R5
  no_stray_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rdData[4:0]) & ~rdData[4:0] & ~$past(wrMask)) == 5'b0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventPulse[0] && wrEn && wrLow[0]) |=> rdData[0]);

  // R7
  irq_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(rdData[4:0] & intEn));

  // R8
  lock0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerRun && cntVal == cmp0Val && !chgSeen[0] && rdData[1]) |=> rdData[1]);

  // R8
  lock1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerRun && cntVal == cmp1Val && !chgSeen[1] && rdData[2]) |=> rdData[2]);
endmodule

bind tmr_evt_status tesr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .eventPulse (eventPulse),
  .intEn      (intEn),
  .timerRun   (timerRun),
  .cntVal     (cntVal),
  .cmp0Val    (cmp0Val),
  .cmp1Val    (cmp1Val),
  .wrEn       (wrEn),
  .wrLow      (wrData[4:0]),
  .chgSeen    (chgSeen),
  .rdData     (rdData),
  .irqOut     (irqOut)
);

// File: tb/tmr_evt_status_tb_top.sv
module tmr_evt_status_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    eventPulse = '0;
  logic [4:0]    intEn = '0;
  logic          timerRun = 1'b1;
  logic [CW-1:0] cntVal = '0, cmp0Val = '0, cmp1Val = '0;
  logic          cntWrStb = 1'b0, cmp0WrStb = 1'b0, cmp1WrStb = 1'b0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          irqOut;

  int    nRun = 0, nFail = 0;
  bit    finished = 1'b0;
  string curReq = "R2";

  logic [4:0] refStat;
  logic [1:0] refChg;

  always #4 clk = ~clk;

  tmr_evt_status #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse), .intEn(intEn),
    .timerRun(timerRun), .cntVal(cntVal), .cmp0Val(cmp0Val), .cmp1Val(cmp1Val),
    .cntWrStb(cntWrStb), .cmp0WrStb(cmp0WrStb), .cmp1WrStb(cmp1WrStb),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    logic [4:0] nxt;
    if (!rstN) begin
      refStat = '0;
      refChg  = '0;
    end else begin
      nxt = refStat;
      for (int i = 0; i < 5; i++) begin
        bit clr;
        clr = wrEn && wrData[i];
        if (i == 1 || i == 2) begin
          logic [CW-1:0] cv;
          cv = (i == 1) ? cmp0Val : cmp1Val;
          if (!timerRun && cv == cntVal && !refChg[i-1]) clr = 1'b0;
        end
        if (eventPulse[i]) nxt[i] = 1'b1;
        else if (clr)      nxt[i] = 1'b0;
      end
      for (int k = 0; k < 2; k++) begin
        if (eventPulse[k+1]) refChg[k] = 1'b0;
        else if (cntWrStb || (k == 0 ? cmp0WrStb : cmp1WrStb)) refChg[k] = 1'b1;
      end
      refStat = nxt;
    end
    #1;
    if (!finished) begin
      chk(rdData == {27'b0, refStat}, {curReq, " model rdData"}, rdData, {27'b0, refStat});
      chk(irqOut == |(refStat & intEn), {curReq, " model irq"}, {31'b0, irqOut},
          {31'b0, |(refStat & intEn)});
    end
  end

  task automatic apply(input logic [4:0] ev, input logic we, input logic [31:0] wd,
                       input logic cs, input logic c0s, input logic c1s);
    @(negedge clk);
    eventPulse = ev; wrEn = we; wrData = wd;
    cntWrStb = cs; cmp0WrStb = c0s; cmp1WrStb = c1s;
    @(posedge clk); #3;
    eventPulse = '0; wrEn = 1'b0; wrData = '0;
    cntWrStb = 1'b0; cmp0WrStb = 1'b0; cmp1WrStb = 1'b0;
  endtask

  task automatic expStat(input string tag, input logic [31:0] exp);
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    expStat("R2 reset status", 32'h0);
    chk(irqOut == 1'b0, "R2 reset irq", {31'b0, irqOut}, 32'h0);
    @(negedge clk) rstN = 1'b1;

    curReq = "R1";
    apply(5'b0, 1'b1, 32'hFFFF_FFE0, 0, 0, 0);
    expStat("R1 reserved write", 32'h0);

    curReq = "R3";
    apply(5'b00001, 0, 0, 0, 0, 0); expStat("R1 R3 overflow bit0", 32'h01);
    apply(5'b00010, 0, 0, 0, 0, 0); expStat("R1 R3 cmp0 bit1", 32'h03);
    apply(5'b00100, 0, 0, 0, 0, 0); expStat("R1 R3 cmp1 bit2", 32'h07);
    apply(5'b01000, 0, 0, 0, 0, 0); expStat("R1 R3 cap0 bit3", 32'h0F);
    apply(5'b10000, 0, 0, 0, 0, 0); expStat("R1 R3 cap1 bit4", 32'h1F);
    chk(irqOut == 1'b0, "R3 masked irq", {31'b0, irqOut}, 32'h0);

    curReq = "R7";
    @(negedge clk) intEn = 5'b00100;
    #1 chk(irqOut == 1'b1, "R7 enabled irq", {31'b0, irqOut}, 32'h1);
    curReq = "R4";
    apply(5'b0, 1, 32'h4, 0, 0, 0);
    expStat("R4 clear bit2", 32'h1B);
    chk(irqOut == 1'b0, "R4 irq drops", {31'b0, irqOut}, 32'h0);

    curReq = "R5";
    apply(5'b0, 1, 32'h0, 0, 0, 0); expStat("R5 write zero", 32'h1B);
    apply(5'b0, 1, 32'h4, 0, 0, 0); expStat("R5 clear of clear bit", 32'h1B);
    chk(irqOut == 1'b0, "R5 irq unchanged", {31'b0, irqOut}, 32'h0);

    curReq = "R4";
    apply(5'b0, 1, 32'h18, 0, 0, 0); expStat("R4 clear captures", 32'h03);

    curReq = "R6";
    apply(5'b00001, 1, 32'h1, 0, 0, 0); expStat("R6 set beats clear", 32'h03);

    curReq = "R10";
    apply(5'b0, 1, 32'h1F, 0, 0, 0); expStat("R10 clear all running", 32'h0);

    curReq = "R8";
    @(negedge clk);
    timerRun = 1'b0; cntVal = 16'd5; cmp0Val = 16'd5; cmp1Val = 16'd9;
    cntWrStb = 1'b1; cmp0WrStb = 1'b1; cmp1WrStb = 1'b1;
    @(negedge clk);
    cntWrStb = 1'b0; cmp0WrStb = 1'b0; cmp1WrStb = 1'b0;
    apply(5'b00010, 0, 0, 0, 0, 0); expStat("R8 cmp0 set", 32'h02);
    apply(5'b0, 1, 32'h2, 0, 0, 0); expStat("R8 cmp0 locked", 32'h02);
    curReq = "R9";
    apply(5'b0, 0, 0, 0, 0, 1);
    apply(5'b0, 1, 32'h2, 0, 0, 0); expStat("R9 other strobe keeps lock", 32'h02);
    apply(5'b0, 0, 0, 0, 1, 0);
    apply(5'b0, 1, 32'h2, 0, 0, 0); expStat("R9 own strobe unlocks", 32'h00);

    curReq = "R8";
    @(negedge clk) begin cmp1Val = 16'd5; cmp1WrStb = 1'b1; end
    @(negedge clk) cmp1WrStb = 1'b0;
    apply(5'b00100, 0, 0, 0, 0, 0); expStat("R8 cmp1 set", 32'h04);
    apply(5'b0, 1, 32'h4, 0, 0, 0); expStat("R8 cmp1 locked", 32'h04);
    curReq = "R9";
    apply(5'b0, 0, 0, 1, 0, 0);
    apply(5'b0, 1, 32'h4, 0, 0, 0); expStat("R9 counter strobe unlocks", 32'h00);
    curReq = "R8";
    apply(5'b00100, 0, 0, 0, 0, 0);
    apply(5'b0, 1, 32'h4, 0, 0, 0); expStat("R8 new event relocks", 32'h04);
    apply(5'b0, 0, 0, 1, 0, 0);
    apply(5'b0, 1, 32'h4, 0, 0, 0); expStat("R9 unlock again", 32'h00);

    curReq = "R10";
    @(negedge clk) timerRun = 1'b1;
    apply(5'b00110, 0, 0, 0, 0, 0); expStat("R10 both cmp set", 32'h06);
    apply(5'b0, 1, 32'h6, 0, 0, 0); expStat("R10 running clears", 32'h00);

    curReq = "R7";
    @(negedge clk) intEn = 5'b11111;
    apply(5'b01000, 0, 0, 0, 0, 0);
    chk(irqOut == 1'b1, "R7 cap0 irq", {31'b0, irqOut}, 32'h1);
    repeat (4) @(posedge clk);
    #3;
    summary();
  end
endmodule